// File: doc/BRIEF.md
# Condition Code and Conditional-Move Unit

This block is the flag logic of the execute stage in a five-stage pipelined 64-bit processor. It keeps three condition flags: zero, sign and signed overflow. An arithmetic or logic instruction in execute rewrites the flags from its result and operands. Jump and conditional-move instructions in execute test the flags against a condition picked by their function field.

The outcome of that test goes into the execute-to-memory stage register. A conditional move whose test fails has its destination register replaced by the null register code, so writeback drops the move. The flags are held in their own register, not in the stage registers. When the pipeline controller bubbles or stalls the execute-to-memory register, the flags are therefore left alone.

Top module: `cc_cmov_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `cc_flags` reads 3'b100 (Z=1, S=0, O=0). In the same window `em_cond` is 0 and `em_dst_e` is 4'hF, the null register code.
- R2: Opcode 4'h6 marks an ALU operation. When `ex_op` is 4'h6 and `ex_bubble` is low, the next cycle's `cc_flags` has bit 2 (Z) set when `ex_alu_res` is zero, and bit 1 (S) equal to the result's most significant bit.
- R3: Bit 0 of `cc_flags` (O) is set after an add (function 0, A+B) or a subtract (function 1, B-A) whose true signed result does not fit 64 bits. It is cleared after an add or subtract that does fit, and always cleared after an and (function 2) or an xor (function 3).
- R4: `cc_flags` keeps its value through any cycle where `ex_op` is not 4'h6 or `ex_bubble` is high. It is not affected by `em_stall` or `em_bubble`.
- R5: The condition for function codes 0 to 6 is: 0 always true, 1 (S^O)|Z, 2 S^O, 3 Z, 4 !Z, 5 !(S^O), 6 !(S^O)&!Z. Codes 7 to 15 are false. The test uses the flags held at the start of the cycle.
- R6: On a load of the stage register, `em_cond` takes the condition result when `ex_op` is 4'h2 (conditional move) or 4'h7 (jump), and takes 0 for any other opcode.
- R7: On a load, `em_dst_e` takes 4'hF for a conditional move whose condition is false. In every other case it takes `ex_dst_e` unchanged.
- R8: When `em_bubble` is high, the next cycle shows `em_cond`=0 and `em_dst_e`=4'hF. This holds even when `em_stall` is also high.
- R9: When `em_stall` is high and `em_bubble` is low, `em_cond` and `em_dst_e` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_op | input | 4 | Opcode of the instruction in execute |
| ex_fn | input | 4 | Function field of the instruction in execute |
| ex_opnd_a | input | 64 | ALU operand A |
| ex_opnd_b | input | 64 | ALU operand B |
| ex_alu_res | input | 64 | ALU result |
| ex_dst_e | input | 4 | Destination register carried into execute |
| ex_bubble | input | 1 | Execute stage holds a bubble; blocks the flag write |
| em_stall | input | 1 | Hold the execute-to-memory register |
| em_bubble | input | 1 | Clear the execute-to-memory register |
| cc_flags | output | 3 | Flags {Z,S,O} |
| em_cond | output | 1 | Latched condition result |
| em_dst_e | output | 4 | Latched destination register, null code when cancelled |

## Verification
In a single cycle, an ALU instruction can write the flags while the controller bubbles or stalls the execute-to-memory register. The bench sets up exactly that cycle. It then checks that the flags still take the new values and that the stage register is cleared or held as commanded. A second overlap comes from back-to-back instructions: a conditional move is tested in the cycle right after the ALU operation that set its flags. The bench judges that case by whether the move's destination survives or becomes the null code.

// File: rtl/cc_unit_pkg.sv
package cc_unit_pkg;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] OPC_CMOV = 4'h2;
  localparam logic [CODE_W-1:0] OPC_ALU  = 4'h6;
  localparam logic [CODE_W-1:0] OPC_JUMP = 4'h7;

  localparam logic [CODE_W-1:0] ALU_ADD = 4'h0;
  localparam logic [CODE_W-1:0] ALU_SUB = 4'h1;
  localparam logic [CODE_W-1:0] ALU_AND = 4'h2;
  localparam logic [CODE_W-1:0] ALU_XOR = 4'h3;

  localparam logic [CODE_W-1:0] CND_ALWAYS = 4'h0;
  localparam logic [CODE_W-1:0] CND_LE     = 4'h1;
  localparam logic [CODE_W-1:0] CND_LT     = 4'h2;
  localparam logic [CODE_W-1:0] CND_EQ     = 4'h3;
  localparam logic [CODE_W-1:0] CND_NE     = 4'h4;
  localparam logic [CODE_W-1:0] CND_GE     = 4'h5;
  localparam logic [CODE_W-1:0] CND_GT     = 4'h6;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } cc_flags_t;

  localparam cc_flags_t CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};
endpackage

// File: rtl/cc_flag_gen.sv
module cc_flag_gen
  import cc_unit_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int FN_W   = 4
) (
  input  logic [FN_W-1:0]   fn,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] alu_res,
  output cc_flags_t         flags_nxt
);
  localparam int WIDE_W = DATA_W + 1;

  logic [WIDE_W-1:0] a_ext;
  logic [WIDE_W-1:0] b_ext;
  logic [WIDE_W-1:0] sum_ext;
  logic [WIDE_W-1:0] dif_ext;
  logic              ovf;

  // Sign-extended one-bit-wider results; overflow when the two top bits disagree.
  assign a_ext   = {opnd_a[DATA_W-1], opnd_a};
  assign b_ext   = {opnd_b[DATA_W-1], opnd_b};
  assign sum_ext = b_ext + a_ext;
  assign dif_ext = b_ext - a_ext;

  always_comb begin
    ovf = 1'b0;
    if (fn == ALU_ADD) begin
      ovf = sum_ext[WIDE_W-1] ^ sum_ext[WIDE_W-2];
    end else if (fn == ALU_SUB) begin
      ovf = dif_ext[WIDE_W-1] ^ dif_ext[WIDE_W-2];
    end
  end

  assign flags_nxt.zf = (alu_res == '0);
  assign flags_nxt.sf = alu_res[DATA_W-1];
  assign flags_nxt.of = ovf;
endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
  import cc_unit_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  cc_flags_t flags_d,
  output cc_flags_t flags_q
);
  // Standalone storage: no bubble or stall input reaches this register.
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= CC_RESET;
    end else if (wr_en) begin
      flags_q <= flags_d;
    end
  end
endmodule

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
  import cc_unit_pkg::*;
#(
  parameter int FN_W = 4
) (
  input  cc_flags_t       flags,
  input  logic [FN_W-1:0] fn,
  output logic            cond
);
  logic lt;

  assign lt = flags.sf ^ flags.of;

  always_comb begin
    case (fn)
      CND_ALWAYS: cond = 1'b1;
      CND_LE:     cond = lt | flags.zf;
      CND_LT:     cond = lt;
      CND_EQ:     cond = flags.zf;
      CND_NE:     cond = ~flags.zf;
      CND_GE:     cond = ~lt;
      CND_GT:     cond = ~lt & ~flags.zf;
      default:    cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/em_cond_reg.sv
module em_cond_reg #(
  parameter int          REG_W    = 4,
  parameter logic [3:0]  NULL_REG = 4'hF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic             bubble,
  input  logic             cond_d,
  input  logic [REG_W-1:0] dst_d,
  output logic             cond_q,
  output logic [REG_W-1:0] dst_q
);
  localparam logic [REG_W-1:0] NULL_CODE = REG_W'(NULL_REG);

  // Bubble wins over stall; stall holds; otherwise load.
  always_ff @(posedge clk) begin
    if (rst || bubble) begin
      cond_q <= 1'b0;
      dst_q  <= NULL_CODE;
    end else if (!stall) begin
      cond_q <= cond_d;
      dst_q  <= dst_d;
    end
  end
endmodule

// File: rtl/cc_cmov_unit.sv
module cc_cmov_unit
  import cc_unit_pkg::*;
#(
  parameter int         DATA_W   = 64,
  parameter int         REG_W    = 4,
  parameter int         OP_W     = 4,
  parameter int         FN_W     = 4,
  parameter logic [3:0] NULL_REG = 4'hF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   ex_op,
  input  logic [FN_W-1:0]   ex_fn,
  input  logic [DATA_W-1:0] ex_opnd_a,
  input  logic [DATA_W-1:0] ex_opnd_b,
  input  logic [DATA_W-1:0] ex_alu_res,
  input  logic [REG_W-1:0]  ex_dst_e,
  input  logic              ex_bubble,
  input  logic              em_stall,
  input  logic              em_bubble,
  output logic [2:0]        cc_flags,
  output logic              em_cond,
  output logic [REG_W-1:0]  em_dst_e
);
  localparam logic [REG_W-1:0] NULL_CODE = REG_W'(NULL_REG);

  cc_flags_t        flags_q;
  cc_flags_t        flags_nxt;
  logic             flag_we;
  logic             cond_raw;
  logic             is_cmov;
  logic             uses_cond;
  logic             e_cond;
  logic [REG_W-1:0] e_dst;

  assign is_cmov   = (ex_op == OP_W'(OPC_CMOV));
  assign uses_cond = is_cmov || (ex_op == OP_W'(OPC_JUMP));
  assign flag_we   = (ex_op == OP_W'(OPC_ALU)) && !ex_bubble;

  cc_flag_gen #(.DATA_W(DATA_W), .FN_W(FN_W)) flag_gen_i (
    .fn        (ex_fn),
    .opnd_a    (ex_opnd_a),
    .opnd_b    (ex_opnd_b),
    .alu_res   (ex_alu_res),
    .flags_nxt (flags_nxt)
  );

  cc_flag_reg flag_reg_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (flag_we),
    .flags_d (flags_nxt),
    .flags_q (flags_q)
  );

  cc_cond_eval #(.FN_W(FN_W)) cond_eval_i (
    .flags (flags_q),
    .fn    (ex_fn),
    .cond  (cond_raw)
  );

  assign e_cond = uses_cond & cond_raw;
  assign e_dst  = (is_cmov && !cond_raw) ? NULL_CODE : ex_dst_e;

  em_cond_reg #(.REG_W(REG_W), .NULL_REG(NULL_REG)) em_reg_i (
    .clk    (clk),
    .rst    (rst),
    .stall  (em_stall),
    .bubble (em_bubble),
    .cond_d (e_cond),
    .dst_d  (e_dst),
    .cond_q (em_cond),
    .dst_q  (em_dst_e)
  );

  assign cc_flags = flags_q;
endmodule

// File: rtl/cc_cmov_unit_chk.sv
module cc_cmov_unit_chk #(
  parameter int DATA_W = 64,
  parameter int REG_W  = 4,
  parameter int OP_W   = 4,
  parameter int FN_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   ex_op,
  input logic [FN_W-1:0]   ex_fn,
  input logic [DATA_W-1:0] ex_alu_res,
  input logic [REG_W-1:0]  ex_dst_e,
  input logic              ex_bubble,
  input logic              em_stall,
  input logic              em_bubble,
  input logic [2:0]        cc_flags,
  input logic              em_cond,
  input logic [REG_W-1:0]  em_dst_e
);
  localparam logic [REG_W-1:0] NULLC = '1;

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (ex_op == 4'h6 && !ex_bubble) |=> (cc_flags[2] == ($past(ex_alu_res) == '0))); // R2
  AST_LOGIC_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (ex_op == 4'h6 && !ex_bubble && (ex_fn == 4'h2 || ex_fn == 4'h3)) |=> !cc_flags[0]); // R3
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ex_op != 4'h6 || ex_bubble) |=> $stable(cc_flags)); // R4
  AST_OTHER_OP_NO_COND: assert property (@(posedge clk) disable iff (rst)
    (ex_op != 4'h2 && ex_op != 4'h7 && !em_stall) |=> !em_cond); // R6
  AST_CMOV_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (ex_op == 4'h2 && !em_stall && !em_bubble) |=> (em_cond || em_dst_e == NULLC)); // R7
  AST_BUBBLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    em_bubble |=> (!em_cond && em_dst_e == NULLC)); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (em_stall && !em_bubble) |=> ($stable(em_cond) && $stable(em_dst_e))); // R9
endmodule

bind cc_cmov_unit cc_cmov_unit_chk #(
  .DATA_W(DATA_W), .REG_W(REG_W), .OP_W(OP_W), .FN_W(FN_W)
) chk_i (
  .clk(clk), .rst(rst), .ex_op(ex_op), .ex_fn(ex_fn), .ex_alu_res(ex_alu_res),
  .ex_dst_e(ex_dst_e), .ex_bubble(ex_bubble), .em_stall(em_stall),
  .em_bubble(em_bubble), .cc_flags(cc_flags), .em_cond(em_cond), .em_dst_e(em_dst_e)
);

// File: tb/cc_cmov_unit_tb.sv
module cc_cmov_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  ex_op, ex_fn, ex_dst_e;
  logic [63:0] ex_opnd_a, ex_opnd_b, ex_alu_res;
  logic        ex_bubble, em_stall, em_bubble;
  logic [2:0]  cc_flags;
  logic        em_cond;
  logic [3:0]  em_dst_e;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic       mz, ms, mo;
  logic       mcond;
  logic [3:0] mdst;

  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;

  always #2 clk = ~clk;

  cc_cmov_unit dut_i (
    .clk(clk), .rst(rst), .ex_op(ex_op), .ex_fn(ex_fn), .ex_opnd_a(ex_opnd_a),
    .ex_opnd_b(ex_opnd_b), .ex_alu_res(ex_alu_res), .ex_dst_e(ex_dst_e),
    .ex_bubble(ex_bubble), .em_stall(em_stall), .em_bubble(em_bubble),
    .cc_flags(cc_flags), .em_cond(em_cond), .em_dst_e(em_dst_e)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic cond_of(logic [3:0] fn);
    case (fn)
      4'd0: return 1'b1;
      4'd1: return (ms ^ mo) | mz;
      4'd2: return ms ^ mo;
      4'd3: return mz;
      4'd4: return !mz;
      4'd5: return !(ms ^ mo);
      4'd6: return !(ms ^ mo) && !mz;
      default: return 1'b0;
    endcase
  endfunction

  // One cycle: drive at negedge, sample 1 ns after the posedge, compare with model.
  task automatic step(string tag, logic [3:0] op, logic [3:0] fn, logic [63:0] a,
                      logic [63:0] b, logic [3:0] dst, logic exb, logic st, logic bub);
    logic [63:0] res;
    logic        c, ovf;
    logic [3:0]  d;
    res = a ^ b ^ 64'h5;
    ovf = 1'b0;
    if (op == 4'h6) begin
      case (fn)
        4'd0: begin res = b + a; ovf = (a[63] == b[63]) && (res[63] != a[63]); end
        4'd1: begin res = b - a; ovf = (a[63] != b[63]) && (res[63] != b[63]); end
        4'd2: res = b & a;
        default: res = b ^ a;
      endcase
    end
    ex_op = op; ex_fn = fn; ex_opnd_a = a; ex_opnd_b = b; ex_alu_res = res;
    ex_dst_e = dst; ex_bubble = exb; em_stall = st; em_bubble = bub;
    c = (op == 4'h2 || op == 4'h7) ? cond_of(fn) : 1'b0;
    d = (op == 4'h2 && !cond_of(fn)) ? 4'hF : dst;
    @(posedge clk);
    #1;
    if (bub) begin mcond = 1'b0; mdst = 4'hF; end
    else if (!st) begin mcond = c; mdst = d; end
    if (op == 4'h6 && !exb) begin mz = (res == 0); ms = res[63]; mo = ovf; end
    check({tag, " flags"}, 64'(cc_flags), 64'({mz, ms, mo}));
    check({tag, " cond"}, 64'(em_cond), 64'(mcond));
    check({tag, " dst"}, 64'(em_dst_e), 64'(mdst));
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1; ex_op = 4'h0; ex_fn = 4'h0; ex_opnd_a = '0; ex_opnd_b = '0;
    ex_alu_res = '0; ex_dst_e = 4'h3; ex_bubble = 1'b0; em_stall = 1'b0; em_bubble = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 flags", 64'(cc_flags), 64'(3'b100));
    check("R1 cond", 64'(em_cond), 64'd0);
    check("R1 dst", 64'(em_dst_e), 64'hF);
    rst = 1'b0;
    mz = 1'b1; ms = 1'b0; mo = 1'b0; mcond = 1'b0; mdst = 4'hF;
  endtask

  task automatic t_alu_flags;
    step("R2 add pos", 4'h6, 4'h0, 64'd3, 64'd4, 4'h1, 0, 0, 0);
    step("R2 sub zero", 4'h6, 4'h1, 64'd5, 64'd5, 4'h1, 0, 0, 0);
    step("R2 and neg", 4'h6, 4'h2, '1, MINN, 4'h1, 0, 0, 0);
    step("R2 xor", 4'h6, 4'h3, 64'hF0, 64'h0F, 4'h1, 0, 0, 0);
  endtask

  task automatic t_overflow;
    step("R3 add ovf", 4'h6, 4'h0, 64'd1, MAXP, 4'h2, 0, 0, 0);
    step("R3 and clr", 4'h6, 4'h2, '1, MINN, 4'h2, 0, 0, 0);
    step("R3 sub ovf", 4'h6, 4'h1, 64'd1, MINN, 4'h2, 0, 0, 0);
    step("R3 xor clr", 4'h6, 4'h3, 64'd1, MINN, 4'h2, 0, 0, 0);
    step("R3 sub ovf2", 4'h6, 4'h1, MINN, 64'd0, 4'h2, 0, 0, 0);
    step("R3 add fit", 4'h6, 4'h0, '1, 64'd1, 4'h2, 0, 0, 0);
  endtask

  task automatic t_hold;
    step("R4 set", 4'h6, 4'h0, 64'd2, 64'd2, 4'h5, 0, 0, 0);
    step("R4 nonalu", 4'h3, 4'h0, 64'd0, 64'd0, 4'h5, 0, 0, 0);
    step("R4 exbub", 4'h6, 4'h1, 64'd9, 64'd9, 4'h5, 1, 0, 0);
    step("R4 embub alu", 4'h6, 4'h1, 64'd9, 64'd9, 4'h5, 0, 0, 1);
    step("R4 emstall alu", 4'h6, 4'h2, '1, MINN, 4'h5, 0, 1, 0);
  endtask

  task automatic t_cond_table;
    // Four flag states: zero, negative, positive, negative-with-overflow.
    for (int s = 0; s < 4; s++) begin
      case (s)
        0: step("R5 mk zero", 4'h6, 4'h1, 64'd7, 64'd7, 4'h0, 0, 0, 0);
        1: step("R5 mk neg", 4'h6, 4'h2, '1, MINN, 4'h0, 0, 0, 0);
        2: step("R5 mk pos", 4'h6, 4'h0, 64'd1, 64'd1, 4'h0, 0, 0, 0);
        default: step("R5 mk ovf", 4'h6, 4'h0, 64'd1, MAXP, 4'h0, 0, 0, 0);
      endcase
      for (int f = 0; f < 16; f++)
        step("R5 R6 jump", 4'h7, 4'(f), 64'd0, 64'd0, 4'h8, 0, 0, 0);
    end
  endtask

  task automatic t_cmov;
    step("R7 mk zero", 4'h6, 4'h3, 64'd6, 64'd6, 4'h0, 0, 0, 0);
    step("R7 cmove true", 4'h2, 4'h3, 64'd0, 64'd0, 4'h4, 0, 0, 0);
    step("R7 cmovne false", 4'h2, 4'h4, 64'd0, 64'd0, 4'h4, 0, 0, 0);
    step("R7 cmov code15", 4'h2, 4'hF, 64'd0, 64'd0, 4'h6, 0, 0, 0);
    step("R7 mk pos", 4'h6, 4'h0, 64'd3, 64'd1, 4'h0, 0, 0, 0);
    step("R7 cmovg true", 4'h2, 4'h6, 64'd0, 64'd0, 4'h7, 0, 0, 0);
    step("R7 jump false keeps dst", 4'h7, 4'h3, 64'd0, 64'd0, 4'h9, 0, 0, 0);
    step("R6 R7 other op", 4'h4, 4'h0, 64'd0, 64'd0, 4'hA, 0, 0, 0);
  endtask

  task automatic t_stall_bubble;
    step("R9 load", 4'h7, 4'h0, 64'd0, 64'd0, 4'hC, 0, 0, 0);
    step("R9 stall1", 4'h2, 4'hF, 64'd0, 64'd0, 4'h1, 0, 1, 0);
    step("R9 stall2", 4'h5, 4'h0, 64'd0, 64'd0, 4'h2, 0, 1, 0);
    step("R8 bub+stall", 4'h7, 4'h0, 64'd0, 64'd0, 4'h3, 0, 1, 1);
    step("R9 reload", 4'h2, 4'h0, 64'd0, 64'd0, 4'hB, 0, 0, 0);
    step("R8 bubble", 4'h2, 4'h0, 64'd0, 64'd0, 4'hB, 0, 0, 1);
  endtask

  initial begin
    t_reset();
    @(negedge clk);
    t_alu_flags();
    t_overflow();
    t_hold();
    t_cond_table();
    t_cmov();
    t_stall_bubble();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule